// File: doc/BRIEF.md
# Crystal Drift Calibration Adjuster

This block divides a crystal-rate tick (nominally 32.768 kHz) down to a one-second pulse and a one-minute pulse. It corrects the crystal's frequency error with a signed 8-bit calibration value. Once per minute, in the last second of the minute, the value times four is taken off that second's tick count.

A crystal that runs slow is given a positive value, so that second ends early; in effect pulses are added to the timer. A crystal that runs fast is given a negative value, so that second runs long; in effect pulses are removed. With a good calibration value the drift stays under about three seconds per month.

The calibration value enters through a valid/ready write channel. Ready is high only when a write is safe: while the timer is stopped, or during a short window at the start of each second. A write offered outside that window is held off by back-pressure. The sender must keep valid and data steady until ready is seen, and no write takes place until then. The value used for a minute's correction is captured when that minute begins, so a write accepted mid-minute applies to the next minute.

Top module: `rtc_drift_adjuster`

## Requirements
- R1: After reset, sec_pulse and min_pulse are low, corr_pulses is 0 and cal_wr_ready is high.
- R2: Every second other than the last one of a minute lasts exactly TICKS_PER_SEC accepted ticks. An accepted tick is a cycle with tick and timer_en both high. sec_pulse is high for exactly one cycle, the cycle after the completing tick.
- R3: The last second of each minute (index SECS_PER_MIN-1) lasts TICKS_PER_SEC - 4*C accepted ticks, where C is the applied calibration value. min_pulse is high only together with the sec_pulse that ends this second.
- R4: cal_wr_data is an 8-bit two's-complement value from -128 to 127. A positive value shortens the last second, which adds pulses. A negative value lengthens it by up to 512 ticks, which removes pulses.
- R5: corr_pulses is the 10-bit two's-complement value of 4*C, for the applied value C.
- R6: The applied value is loaded from the calibration register at each minute rollover. A write accepted during a minute does not change that minute's correction or corr_pulses before the next rollover.
- R7: cal_wr_ready is high when timer_en is low, or when fewer than WRITE_WIN_TICKS ticks have been accepted in the current second. A write takes effect only on a cycle with cal_wr_valid and cal_wr_ready both high.
- R8: While timer_en is low, ticks are ignored, the count holds and no pulses are produced. The applied value tracks the register, including a write accepted in that cycle.
- R9: A calibration value of 0 gives every second exactly TICKS_PER_SEC ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the crystal rate |
| timer_en | input | 1 | Timer running; low stops counting |
| cal_wr_valid | input | 1 | Calibration write offered |
| cal_wr_data | input | 8 | Signed calibration value |
| cal_wr_ready | output | 1 | Write can be taken this cycle |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |
| min_pulse | output | 1 | One-cycle pulse at each minute boundary |
| corr_pulses | output | 10 | Signed correction applied this minute (4*C) |

## Verification
The hardest case to reach is a calibration write that lands mid-minute, together with a stop of the timer that falls inside the stretched or shortened last second. In that case the applied value changes under a count that is already partly done. Random stimulus offers writes at random cycles, and many of them are held off by back-pressure until a second-start window opens. It also stops the timer at random for short spells and issues writes while it is stopped. A directed sequence of the extreme values 127 and -128, plus 0 and ±1, runs first. A tick-level model in the bench predicts every pulse.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_W    = 8;
  localparam int CORR_W   = CAL_W + 2;
  localparam int CORR_MAG = 4 * (1 << (CAL_W - 1));

  typedef logic signed [CAL_W-1:0]  cal_t;
  typedef logic signed [CORR_W-1:0] corr_t;

  // times four in two's complement: append two zero bits
  function automatic corr_t scale_cal(input cal_t v);
    return corr_t'({v, 2'b00});
  endfunction
endpackage

// File: rtl/cal_write_port.sv
module cal_write_port
  import rtc_cal_pkg::*;
#(
  parameter int WRITE_WIN_TICKS = 256,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_en,
  input  logic [CNT_W-1:0] phase,
  input  logic             wr_valid,
  input  logic [CAL_W-1:0] wr_data,
  output logic             wr_ready,
  output cal_t             cal_next
);
  cal_t cal_q;

  assign wr_ready = !timer_en || (int'(phase) < WRITE_WIN_TICKS);
  assign cal_next = (wr_valid && wr_ready) ? cal_t'(wr_data) : cal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cal_q <= '0;
    else        cal_q <= cal_next;
  end

  // R7: a write refused by back-pressure leaves the register untouched
  p_blocked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(cal_q));
endmodule

// File: rtl/cal_applier.sv
module cal_applier
  import rtc_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  timer_en,
  input  logic  minute_roll,
  input  cal_t  cal_next,
  output corr_t corr
);
  cal_t applied_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        applied_q <= '0;
    else if (!timer_en || minute_roll) applied_q <= cal_next;
  end

  assign corr = scale_cal(applied_q);

  // R6: correction moves only at a minute rollover or while stopped
  p_corr_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(corr) |-> $past(!timer_en || minute_roll));
endmodule

// File: rtl/cal_tick_prescaler.sv
module cal_tick_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             timer_en,
  input  logic             last_sec,
  input  corr_t            corr,
  output logic [CNT_W-1:0] phase,
  output logic             sec_roll,
  output logic             sec_pulse
);
  int period;

  always_comb begin
    if (last_sec) period = TICKS_PER_SEC - int'(corr);
    else          period = TICKS_PER_SEC;
  end

  assign sec_roll = timer_en && tick && ((int'(phase) + 1) >= period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= sec_roll;
      if (sec_roll)              phase <= '0;
      else if (timer_en && tick) phase <= phase + 1'b1;
    end
  end

  // R8: stopped timer holds its count and emits nothing
  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_en |=> ($stable(phase) && !sec_pulse));
  // R2: second pulse lasts a single cycle
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);
  // R3: count never runs past the longest corrected second
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < TICKS_PER_SEC + CORR_MAG);
endmodule

// File: rtl/cal_second_counter.sv
module cal_second_counter #(
  parameter int SECS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_roll,
  output logic last_sec,
  output logic minute_roll,
  output logic min_pulse
);
  localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;

  logic [SEC_W-1:0] idx;

  assign last_sec    = (idx == SEC_W'(SECS_PER_MIN - 1));
  assign minute_roll = sec_roll && last_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      min_pulse <= 1'b0;
    end else begin
      min_pulse <= minute_roll;
      if (sec_roll) idx <= last_sec ? '0 : idx + 1'b1;
    end
  end

  // R3: seconds index stays inside the minute
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < SECS_PER_MIN);
endmodule

// File: rtl/rtc_drift_adjuster.sv
module rtc_drift_adjuster
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC   = 32768,
  parameter int SECS_PER_MIN    = 60,
  parameter int WRITE_WIN_TICKS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              timer_en,
  input  logic              cal_wr_valid,
  input  logic [7:0]        cal_wr_data,
  output logic              cal_wr_ready,
  output logic              sec_pulse,
  output logic              min_pulse,
  output logic signed [9:0] corr_pulses
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC + CORR_MAG + 1);

  logic [CNT_W-1:0] phase;
  logic             sec_roll, last_sec, minute_roll;
  cal_t             cal_next;
  corr_t            corr;

  cal_write_port #(.WRITE_WIN_TICKS(WRITE_WIN_TICKS), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .phase(phase),
    .wr_valid(cal_wr_valid), .wr_data(cal_wr_data),
    .wr_ready(cal_wr_ready), .cal_next(cal_next)
  );

  cal_applier u_apply (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en),
    .minute_roll(minute_roll), .cal_next(cal_next), .corr(corr)
  );

  cal_tick_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .timer_en(timer_en),
    .last_sec(last_sec), .corr(corr), .phase(phase),
    .sec_roll(sec_roll), .sec_pulse(sec_pulse)
  );

  cal_second_counter #(.SECS_PER_MIN(SECS_PER_MIN)) u_sec (
    .clk(clk), .rst_n(rst_n), .sec_roll(sec_roll),
    .last_sec(last_sec), .minute_roll(minute_roll), .min_pulse(min_pulse)
  );

  assign corr_pulses = corr;

  // R3: a minute boundary is always also a second boundary
  p_min_with_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_pulse |-> sec_pulse);
endmodule

// File: tb/rtc_drift_adjuster_tb.sv
module rtc_drift_adjuster_tb_top;
  localparam int TICKS = 640;
  localparam int SECS  = 3;
  localparam int WIN   = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick, timer_en, cal_wr_valid;
  logic [7:0]        cal_wr_data;
  logic              cal_wr_ready, sec_pulse, min_pulse;
  logic signed [9:0] corr_pulses;

  int  compared = 0;
  int  mismatched = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  rtc_drift_adjuster #(.TICKS_PER_SEC(TICKS), .SECS_PER_MIN(SECS),
                       .WRITE_WIN_TICKS(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .timer_en(timer_en),
    .cal_wr_valid(cal_wr_valid), .cal_wr_data(cal_wr_data),
    .cal_wr_ready(cal_wr_ready), .sec_pulse(sec_pulse),
    .min_pulse(min_pulse), .corr_pulses(corr_pulses)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sec_len(input int idx, input int app);
    return (idx == SECS - 1) ? TICKS - 4 * app : TICKS;
  endfunction

  initial begin
    int  m_cnt = 0, m_sec = 0, m_reg = 0, m_app = 0, m_used = 0;
    int  minutes = 0, off_left = 0, dir_idx = 0;
    bit  exp_sec = 0, exp_min = 0, fired = 0, exp_ready;
    int  dir [6] = '{127, -128, 0, 1, -1, -77};
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick = 1'b0; timer_en = 1'b1;
    cal_wr_valid = 1'b0; cal_wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sec_pulse && !min_pulse, "R1 pulses after reset", int'(sec_pulse), 0);
    check(corr_pulses == 0, "R1 corr after reset", int'(corr_pulses), 0);
    check(cal_wr_ready, "R1 ready after reset", int'(cal_wr_ready), 1);

    while (minutes < 20) begin
      if (sec_pulse || exp_sec) begin
        if (exp_sec && exp_min)
          check(sec_pulse == exp_sec, (m_used == 0) ? "R9 zero-cal last second"
                : "R4 signed-cal last second", int'(sec_pulse), int'(exp_sec));
        else
          check(sec_pulse == exp_sec, "R2 plain second length", int'(sec_pulse), int'(exp_sec));
      end
      if (min_pulse || exp_min)
        check(min_pulse == exp_min, "R3 minute boundary", int'(min_pulse), int'(exp_min));
      if (exp_min) begin
        check(int'(corr_pulses) == 4 * m_app, "R5 R6 correction latched at rollover",
              int'(corr_pulses), 4 * m_app);
        minutes++;
      end
      if (!timer_en)
        check(!sec_pulse && !min_pulse, "R8 no pulse while stopped", int'(sec_pulse), 0);
      exp_sec = 0; exp_min = 0;

      if (fired) begin cal_wr_valid = 1'b0; fired = 0; end

      if (off_left > 0) begin
        off_left--; timer_en = 1'b0;
      end else begin
        timer_en = 1'b1;
        if ($urandom_range(0, 2999) == 0) off_left = $urandom_range(20, 60);
      end
      tick = ($urandom_range(0, 9) < 7);
      if (!cal_wr_valid && ($urandom_range(0, 399) == 0 ||
          (!timer_en && $urandom_range(0, 9) == 0))) begin
        cal_wr_valid = 1'b1;
        if (dir_idx < 6) begin
          cal_wr_data = 8'(dir[dir_idx]); dir_idx++;
        end else cal_wr_data = 8'($urandom_range(0, 255));
      end

      #1;
      exp_ready = !timer_en || (m_cnt < WIN);
      if (cal_wr_valid)
        check(cal_wr_ready == exp_ready, timer_en ? "R7 write window" : "R8 R7 ready when stopped",
              int'(cal_wr_ready), int'(exp_ready));
      if (cal_wr_valid && exp_ready) begin
        fired = 1;
        m_reg = int'($signed(cal_wr_data));
      end
      if (!timer_en) m_app = m_reg;
      else if (tick) begin
        m_cnt++;
        if (m_cnt >= sec_len(m_sec, m_app)) begin
          m_cnt = 0; exp_sec = 1;
          if (m_sec == SECS - 1) begin
            exp_min = 1; m_used = m_app; m_app = m_reg; m_sec = 0;
          end else m_sec++;
        end
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R2 watchdog expired: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule